// File: doc/BRIEF.md
# Address-Event Splitter/Merger Switch

This block joins several address-event ports, each using a four-phase request/acknowledge handshake with active-high signals. A static mode input selects one of two roles. As a splitter, events arriving on source channel 0 go to the sink channels. They are either copied to every enabled sink, or sent to the one sink whose inclusive address window contains the event address. As a merger, events from all source channels are arbitrated onto sink channel 0. The source channel number can be prepended to the address so that downstream logic knows where each event came from.

Only one event is in flight at a time. An event is captured when a source raises its request. It is presented on the selected sinks and held there until every one of them has acknowledged and released. Only then is the source acknowledged. All handshake inputs are assumed to be synchronous to `clk`. All configuration inputs are treated as static while events are in flight.

Top module: `aer_switch`

## Requirements
- R1: While reset is asserted, and on leaving it, every source acknowledge and every sink request is low.
- R2: In splitter copy mode (`cfg_merge`=0, `cfg_range`=0), an event on source 0 is presented on every sink whose `cfg_en` bit is 1 and on no other sink. The sink address carries the event address in its low AW bits and zeros in its top TW bits.
- R3: Source acknowledge rises only after every targeted sink has seen its request rise, has acknowledged it, and has dropped both request and acknowledge again.
- R4: In splitter range mode (`cfg_range`=1), sink i is a candidate when `cfg_en[i]`=1 and lo_i <= address <= hi_i, with both bounds inclusive. The event goes only to the lowest-numbered candidate.
- R5: In range mode, an event with no candidate sink is acknowledged to source 0 and raises no sink request.
- R6: In splitter mode, requests on sources 1 to 3 are ignored: their acknowledges stay low and they cause no sink activity.
- R7: In merger mode (`cfg_merge`=1), every event from any source appears on sink 0 only. Sinks 1 to 3 stay idle.
- R8: Merger arbitration is round-robin. The search starts at the channel after the last one granted, and after reset the search starts at channel 0.
- R9: In merger mode, only the granted source is acknowledged. The sink address stays stable while a sink request waits for its acknowledge.
- R10: In merger mode with `cfg_tag`=1, the sink address is {source index (TW bits), event address}. With `cfg_tag`=0, the top TW bits are zero.
- R11: A sink request never falls before its acknowledge is seen high. A source acknowledge never falls while the source request is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_merge | input | 1 | 1 = merger mode, 0 = splitter mode |
| cfg_range | input | 1 | Splitter: 1 = route by address window, 0 = copy to enabled sinks |
| cfg_tag | input | 1 | Merger: 1 = prepend source index to address |
| cfg_en | input | NCH | Splitter sink enables |
| cfg_lo | input | NCH*AW | Inclusive lower bound per sink, sink i at bits [i*AW +: AW] |
| cfg_hi | input | NCH*AW | Inclusive upper bound per sink, same packing |
| src_req | input | NCH | Source requests |
| src_addr | input | NCH*AW | Source addresses, channel i at bits [i*AW +: AW] |
| src_ack | output | NCH | Source acknowledges |
| snk_req | output | NCH | Sink requests |
| snk_addr | output | AW+TW | Address shared by all sinks |
| snk_ack | input | NCH | Sink acknowledges |

## Verification
Copy mode is driven with all sinks enabled and with a sparse enable mask, and each sink answers after a different delay. This separates a release that waits for the slowest sink from one that waits only for the first sink. Range mode uses overlapping windows, events exactly on the bounds, an address outside every window and a window whose sink is disabled. These cases distinguish inclusive from exclusive compares, lowest-index priority from any other priority, and dropping an event from hanging on it. Merger mode is driven with all four sources requesting at once and then with two sources that a fixed-priority arbiter would order differently from a rotating one, both with and without tagging. A request on a non-zero source in splitter mode shows whether those inputs leak through.

// File: rtl/aer_switch.sv
module aer_switch #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  localparam int TW = $clog2(NCH),
  localparam int OW = AW + TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_merge,
  input  logic              cfg_range,
  input  logic              cfg_tag,
  input  logic [NCH-1:0]    cfg_en,
  input  logic [NCH*AW-1:0] cfg_lo,
  input  logic [NCH*AW-1:0] cfg_hi,
  input  logic [NCH-1:0]    src_req,
  input  logic [NCH*AW-1:0] src_addr,
  output logic [NCH-1:0]    src_ack,
  output logic [NCH-1:0]    snk_req,
  output logic [OW-1:0]     snk_addr,
  input  logic [NCH-1:0]    snk_ack
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RELEASE, ST_DONE} st_t;

  st_t            st;
  logic [TW-1:0]  sel, last, rr_idx;
  logic [NCH-1:0] tgt, hit, rng_pick, split_mask;
  logic [OW-1:0]  oaddr;
  logic [NCH-1:0] src_ack_r, snk_req_r;
  logic [AW-1:0]  a0;
  logic           start;

  assign a0 = src_addr[AW-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_win
    assign hit[i] = cfg_en[i] && (a0 >= cfg_lo[i*AW +: AW]) && (a0 <= cfg_hi[i*AW +: AW]);
  end

  always_comb begin
    rng_pick = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (hit[i]) begin
        rng_pick    = '0;
        rng_pick[i] = 1'b1;
      end
  end

  assign split_mask = cfg_range ? rng_pick : cfg_en;

  always_comb begin
    logic found;
    found  = 1'b0;
    rr_idx = last;
    for (int k = 1; k <= NCH; k++) begin
      logic [TW-1:0] idx;
      idx = TW'((int'(last) + k) % NCH);
      if (!found && src_req[idx]) begin
        found  = 1'b1;
        rr_idx = idx;
      end
    end
  end

  assign start = cfg_merge ? (|src_req) : src_req[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sel       <= '0;
      last      <= TW'(NCH-1);
      tgt       <= '0;
      oaddr     <= '0;
      src_ack_r <= '0;
      snk_req_r <= '0;
    end else begin
      unique case (st)
        ST_IDLE:
          if (start) begin
            if (cfg_merge) begin
              sel       <= rr_idx;
              last      <= rr_idx;
              tgt       <= NCH'(1);
              snk_req_r <= NCH'(1);
              oaddr     <= {(cfg_tag ? rr_idx : TW'(0)), src_addr[int'(rr_idx)*AW +: AW]};
              st        <= ST_SEND;
            end else begin
              sel   <= '0;
              tgt   <= split_mask;
              oaddr <= {TW'(0), a0};
              if (split_mask != '0) begin
                snk_req_r <= split_mask;
                st        <= ST_SEND;
              end else begin
                src_ack_r[0] <= 1'b1;
                st           <= ST_DONE;
              end
            end
          end
        ST_SEND:
          if ((snk_ack & tgt) == tgt) begin
            snk_req_r <= '0;
            st        <= ST_RELEASE;
          end
        ST_RELEASE:
          if ((snk_ack & tgt) == '0) begin
            src_ack_r[sel] <= 1'b1;
            st             <= ST_DONE;
          end
        ST_DONE:
          if (!src_req[sel]) begin
            src_ack_r <= '0;
            st        <= ST_IDLE;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign src_ack  = src_ack_r;
  assign snk_req  = snk_req_r;
  assign snk_addr = oaddr;

  assert_one_src_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack));

  assert_split_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_merge |-> src_ack[NCH-1:1] == '0);

  assert_merge_one_sink_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_merge |-> snk_req[NCH-1:1] == '0);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(snk_req & ~snk_ack)) |=> $stable(snk_addr));

  assert_ack_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|src_ack) |-> (snk_req == '0) && ((snk_ack & tgt) == '0));

  assert_tag_matches_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_merge && cfg_tag && snk_req[0]) |-> src_req[snk_addr[OW-1 -: TW]]);

  for (genvar i = 0; i < NCH; i++) begin : g_hs
    assert_snk_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_req[i] && !snk_ack[i]) |=> snk_req[i]);
    assert_src_ack_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ack[i] && src_req[i]) |=> src_ack[i]);
  end

endmodule

// File: tb/test_aer_switch.sv
`timescale 1ns/1ps
module test_aer_switch;
  localparam int NCH = 4, AW = 8, TW = 2, OW = AW + TW;

  logic clk = 0, rst_n = 0;
  logic cfg_merge = 0, cfg_range = 0, cfg_tag = 0;
  logic [NCH-1:0] cfg_en = '1;
  logic [NCH*AW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [NCH-1:0] src_req = '0;
  logic [NCH*AW-1:0] src_addr = '0;
  logic [NCH-1:0] src_ack, snk_req;
  logic [OW-1:0] snk_addr;
  logic [NCH-1:0] snk_ack = '0;

  aer_switch #(.NCH(NCH), .AW(AW)) i_aer_switch (
    .clk(clk), .rst_n(rst_n), .cfg_merge(cfg_merge), .cfg_range(cfg_range),
    .cfg_tag(cfg_tag), .cfg_en(cfg_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack),
    .snk_req(snk_req), .snk_addr(snk_addr), .snk_ack(snk_ack));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur = "R1";
  logic [OW-1:0] q0[$], q1[$], q2[$], q3[$];
  int dly[NCH] = '{1, 3, 0, 7};
  int cnt[NCH] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int s, input logic [OW-1:0] v);
    case (s)
      0: q0.push_back(v);
      1: q1.push_back(v);
      2: q2.push_back(v);
      default: q3.push_back(v);
    endcase
  endtask

  function automatic int qsize(input int s);
    case (s)
      0: return q0.size();
      1: return q1.size();
      2: return q2.size();
      default: return q3.size();
    endcase
  endfunction

  task automatic pop_check(input int s, input logic [OW-1:0] got);
    logic [OW-1:0] e;
    n_chk++;
    if (qsize(s) == 0) begin
      n_fail++;
      $display("FAIL %s sink%0d unexpected actual=%0h expected=none", cur, s, got);
      return;
    end
    case (s)
      0: e = q0.pop_front();
      1: e = q1.pop_front();
      2: e = q2.pop_front();
      default: e = q3.pop_front();
    endcase
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s sink%0d actual=%0h expected=%0h", cur, s, got, e);
    end
  endtask

  // monitor and sink responders
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (snk_req[i] && !snk_ack[i]) begin
        if (cnt[i] >= dly[i]) begin
          pop_check(i, snk_addr);
          snk_ack[i] = 1'b1;
          cnt[i] = 0;
        end else cnt[i]++;
      end else if (!snk_req[i] && snk_ack[i]) snk_ack[i] = 1'b0;
    end
  end

  task automatic send(input int ch, input logic [AW-1:0] a, input bit want_empty);
    @(negedge clk);
    src_addr[ch*AW +: AW] = a;
    src_req[ch] = 1'b1;
    do @(negedge clk); while (!src_ack[ch]);
    if (want_empty)
      chk(q0.size() + q1.size() + q2.size() + q3.size() == 0 && snk_req == '0,
          "R3 source ack before all sinks done", {28'd0, snk_req}, 0);
    src_req[ch] = 1'b0;
    do @(negedge clk); while (src_ack[ch]);
  endtask

  task automatic rsend(input logic [AW-1:0] a, input int s);
    if (s >= 0) push(s, {TW'(0), a});
    send(0, a, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(src_ack == '0 && snk_req == '0, "R1 outputs in reset", {src_ack, snk_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(src_ack == '0 && snk_req == '0, "R1 outputs after reset", {src_ack, snk_req}, 0);

    // R2 copy to all, R3 waits for slowest sink
    cur = "R2";
    for (int s = 0; s < NCH; s++) push(s, {TW'(0), 8'h5A});
    send(0, 8'h5A, 1);
    cfg_en = 4'b1011;
    push(0, 10'h0A3); push(1, 10'h0A3); push(3, 10'h0A3);
    send(0, 8'hA3, 1);
    cfg_en = 4'b0100;
    push(2, 10'h001);
    send(0, 8'h01, 1);

    // R6 non-zero sources ignored in splitter mode
    cur = "R6";
    @(negedge clk);
    src_addr[2*AW +: AW] = 8'h77;
    src_req[2] = 1'b1;
    src_req[3] = 1'b1;
    repeat (20) @(negedge clk);
    chk(src_ack == '0, "R6 source ack stays low", {28'd0, src_ack}, 0);
    chk(snk_req == '0, "R6 no sink request", {28'd0, snk_req}, 0);
    src_req[2] = 1'b0;
    src_req[3] = 1'b0;

    // R4 / R5 range routing
    cur = "R4";
    cfg_en = '1;
    cfg_range = 1;
    cfg_lo = {8'hC0, 8'h30, 8'h40, 8'h00};
    cfg_hi = {8'hFF, 8'h9F, 8'h7F, 8'h3F};
    rsend(8'h10, 0);
    rsend(8'h35, 0);
    rsend(8'h3F, 0);
    rsend(8'h50, 1);
    rsend(8'h90, 2);
    rsend(8'hC0, 3);
    rsend(8'hFF, 3);
    cur = "R5";
    rsend(8'hA5, -1);
    chk(1'b1, "R5 unmatched event acknowledged", 0, 0);
    cfg_en = 4'b0111;
    rsend(8'hD0, -1);
    rsend(8'h45, 1);
    cfg_en = 4'b0101;
    cur = "R4";
    rsend(8'h45, 2);

    // R7 merge without tag, R10 upper bits zero
    cur = "R7";
    cfg_range = 0;
    cfg_en = '1;
    cfg_merge = 1;
    push(0, {2'd0, 8'h11});
    send(2, 8'h11, 1);
    push(0, {2'd0, 8'h22});
    send(3, 8'h22, 1);

    // R8 / R10 all four at once, tagged; last grant was 3 so order 0,1,2,3
    cur = "R8";
    cfg_tag = 1;
    push(0, {2'd0, 8'hA0}); push(0, {2'd1, 8'hA1});
    push(0, {2'd2, 8'hA2}); push(0, {2'd3, 8'hA3});
    fork
      send(0, 8'hA0, 0);
      send(1, 8'hA1, 0);
      send(2, 8'hA2, 0);
      send(3, 8'hA3, 0);
    join
    chk(q0.size() == 0, "R8 all four served", q0.size(), 0);

    // R8 rotation: after channel 1, channel 3 beats channel 0
    push(0, {2'd1, 8'h5B});
    send(1, 8'h5B, 1);
    push(0, {2'd3, 8'hC3}); push(0, {2'd0, 8'hC0});
    fork
      send(0, 8'hC0, 0);
      send(3, 8'hC3, 0);
    join
    chk(q0.size() == 0, "R8 rotation served", q0.size(), 0);

    cur = "R10";
    push(0, {2'd2, 8'hEE});
    send(2, 8'hEE, 1);
    cfg_tag = 0;
    push(0, {2'd0, 8'hEF});
    send(1, 8'hEF, 1);

    repeat (5) @(negedge clk);
    chk(snk_req == '0 && src_ack == '0, "R11 idle at end", {src_ack, snk_req}, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog %s actual=hung expected=done", cur);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule